// File: doc/BRIEF.md
# Single-Precision Float to Fixed-Point Converter

This block turns an IEEE 754 single-precision value into a fixed-point integer, either 16 or 32 bits wide and either signed or unsigned. Each operation picks how many fraction bits (0 to 32) the result keeps. The input is scaled by two to that power without error, because the count is added to the exponent. The scaled value is then rounded to an integer using one of four rounding directions. If the result does not fit in the chosen range, it is clamped to the nearest limit.

The block has a single register stage. An operation is presented with `in_valid` together with its operand and controls. Exactly one cycle later `out_valid` rises, carrying the 32-bit result and two flags, invalid and inexact. A 16-bit result is widened to 32 bits: sign-extended when signed and zero-extended when unsigned. A per-operation override bit forces truncation toward zero whatever rounding direction is configured. This is the behaviour a conversion instruction with a built-in truncate needs.

Top module: `f2x_convert`

## Requirements
- R1: The result equals the operand multiplied by 2^N, where N is the fraction-bit count, rounded to an integer. Counts above 32 act as 32. When the value fits, the signed result is given in two's complement.
- R2: The rounding field selects the direction: 0 is nearest with ties to even, 1 is toward +infinity, 2 is toward -infinity and 3 is toward zero.
- R3: When the override bit is 1, rounding is toward zero whatever the rounding field holds.
- R4: A NaN operand (exponent field all ones, nonzero fraction) gives a result of 0 with invalid set and inexact clear.
- R5: When the result is in range, inexact is set exactly when the scaled value had a nonzero discarded fraction. Invalid stays clear.
- R6: A rounded value below the range minimum gives the minimum with invalid set and inexact clear. The minimum is -32768 for signed 16-bit, -2^31 for signed 32-bit, and 0 for unsigned.
- R7: A rounded value above the range maximum gives the maximum with invalid set and inexact clear. The maximum is 32767, 2^31-1, 65535 or 2^32-1, according to signedness and width.
- R8: For an unsigned result, a negative operand that rounds to a nonzero magnitude gives 0 with invalid set. A negative operand that rounds to zero gives 0 with only inexact set, if anything was discarded.
- R9: An infinite operand clamps to the limit on its own side with invalid set. That limit is 0 for negative infinity with an unsigned result.
- R10: A subnormal operand gives 0 with inexact set, in every rounding direction. A signed or unsigned zero gives 0 with no flags.
- R11: A 16-bit signed result is sign-extended to 32 bits, and a 16-bit unsigned result is zero-extended.
- R12: `out_valid` follows `in_valid` one cycle later. Both flags are low whenever `out_valid` is low. `out_data` holds its value through cycles with no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_bits | input | 32 | Single-precision operand |
| in_signed | input | 1 | 1 selects a signed result |
| in_half | input | 1 | 1 selects a 16-bit result range |
| in_fbits | input | 6 | Fraction-bit count; values above 32 act as 32 |
| in_force_rz | input | 1 | Forces rounding toward zero |
| in_rmode | input | 2 | Rounding direction (encoding in R2) |
| out_valid | output | 1 | Result valid |
| out_data | output | 32 | Extended fixed-point result |
| out_invalid | output | 1 | Invalid flag, valid with out_valid |
| out_inexact | output | 1 | Inexact flag, valid with out_valid |

## Verification
Exact halfway operands (k + 0.5) are scaled down by the fraction count, and the count is swept through 0, 1, 15, 16, 31 and 32. This shows whether each rounding direction, and the tie-to-even rule, sees the right guard bit at every alignment. Values just outside and just inside each of the four ranges separate correct clamping from off-by-one limits, and show whether inexact is dropped on saturation. NaNs, infinities, subnormals and negative zero-crossings with unsigned results exercise the special paths. Each result is compared with a model in the bench built on real arithmetic, and key cases are also checked against hand-worked constants.

// File: rtl/f2x_pkg.sv
package f2x_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int BIAS   = 127;
    localparam int OUT_W  = 32;
    localparam int HALF_W = 16;
    localparam int MAX_FB = 32;
    localparam int FB_W   = 6;
    localparam int SH_W   = 10;
    // Magnitudes up to 2^33 must be representable for the clamp compare.
    localparam int MAG_W  = OUT_W + 2;
    // Left shifts at or beyond this always exceed every range.
    localparam int BIG_SH = OUT_W - SIG_W + 1;
    // Right-shift window: significand plus enough room for guard/sticky.
    localparam int RWIN   = 40;
    localparam int ZBIAS  = BIAS + FRAC_W;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_UP   = 2'd1,
        RM_DOWN = 2'd2,
        RM_ZERO = 2'd3
    } rmode_e;

    typedef enum logic [2:0] {
        K_ZERO, K_SUB, K_NORM, K_INF, K_NAN
    } kind_e;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] data;
        logic             inv;
        logic             inx;
    } stage_t;
endpackage

// File: rtl/f2x_unpack.sv
module f2x_unpack
    import f2x_pkg::*;
(
    input  logic [OUT_W-1:0]       bits_i,
    input  logic [FB_W-1:0]        fbits_i,
    output kind_e                  kind_o,
    output logic                   neg_o,
    output logic [SIG_W-1:0]       sig_o,
    output logic signed [SH_W-1:0] shift_o
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic [FB_W-1:0]   fb_c;

    always_comb begin
        exp_f  = bits_i[FRAC_W +: EXP_W];
        frac_f = bits_i[FRAC_W-1:0];
        neg_o  = bits_i[OUT_W-1];
        fb_c   = (fbits_i > FB_W'(MAX_FB)) ? FB_W'(MAX_FB) : fbits_i;
        sig_o  = {1'b1, frac_f};
        // Exponent of the integer significand's LSB after scaling by 2^fb.
        shift_o = $signed(SH_W'(exp_f)) + $signed(SH_W'(fb_c)) - SH_W'(ZBIAS);
        if (exp_f == '1)
            kind_o = (frac_f != '0) ? K_NAN : K_INF;
        else if (exp_f == '0)
            kind_o = (frac_f != '0) ? K_SUB : K_ZERO;
        else
            kind_o = K_NORM;
    end
endmodule

// File: rtl/f2x_round.sv
module f2x_round
    import f2x_pkg::*;
(
    input  logic [SIG_W-1:0]       sig_i,
    input  logic signed [SH_W-1:0] shift_i,
    input  logic                   neg_i,
    input  rmode_e                 mode_i,
    output logic [MAG_W-1:0]       mag_o,
    output logic                   big_o,
    output logic                   lost_o
);
    localparam int WIDE_W = SIG_W + RWIN;

    logic [SH_W-1:0]   rsh;
    logic [5:0]        rc;
    logic [WIDE_W-1:0] wide;
    logic [SIG_W-1:0]  ipart;
    logic              rnd, stk, inc;

    always_comb begin
        big_o  = 1'b0;
        mag_o  = '0;
        lost_o = 1'b0;
        rsh    = SH_W'(-shift_i);
        rc     = (rsh > SH_W'(RWIN)) ? 6'(RWIN) : rsh[5:0];
        wide   = {sig_i, {RWIN{1'b0}}} >> rc;
        ipart  = wide[WIDE_W-1 -: SIG_W];
        rnd    = wide[RWIN-1];
        stk    = |wide[RWIN-2:0];
        unique case (mode_i)
            RM_NEAR: inc = rnd & (stk | ipart[0]);
            RM_UP:   inc = ~neg_i & (rnd | stk);
            RM_DOWN: inc = neg_i & (rnd | stk);
            default: inc = 1'b0;
        endcase
        if (shift_i >= $signed(SH_W'(BIG_SH))) begin
            big_o = 1'b1;
        end else if (shift_i >= 0) begin
            mag_o = MAG_W'(sig_i) << shift_i[3:0];
        end else begin
            lost_o = rnd | stk;
            mag_o  = MAG_W'(ipart) + MAG_W'(inc);
        end
    end
endmodule

// File: rtl/f2x_clamp.sv
module f2x_clamp
    import f2x_pkg::*;
(
    input  kind_e            kind_i,
    input  logic             neg_i,
    input  logic [MAG_W-1:0] mag_i,
    input  logic             big_i,
    input  logic             lost_i,
    input  logic             signed_i,
    input  logic             half_i,
    output logic [OUT_W-1:0] data_o,
    output logic             inv_o,
    output logic             inx_o
);
    localparam logic [MAG_W-1:0] S16_NEG = MAG_W'(1) << (HALF_W - 1);
    localparam logic [MAG_W-1:0] S32_NEG = MAG_W'(1) << (OUT_W - 1);
    localparam logic [MAG_W-1:0] U16_POS = (MAG_W'(1) << HALF_W) - 1;
    localparam logic [MAG_W-1:0] U32_POS = (MAG_W'(1) << OUT_W) - 1;

    logic [MAG_W-1:0] lim_pos, lim_neg;
    logic             over;

    always_comb begin
        if (signed_i) begin
            lim_neg = half_i ? S16_NEG : S32_NEG;
            lim_pos = lim_neg - 1'b1;
        end else begin
            lim_neg = '0;
            lim_pos = half_i ? U16_POS : U32_POS;
        end
        over   = big_i | (kind_i == K_INF);
        data_o = '0;
        inv_o  = 1'b0;
        inx_o  = 1'b0;
        unique case (kind_i)
            K_NAN:  inv_o = 1'b1;
            K_ZERO: inv_o = 1'b0;
            K_SUB:  inx_o = 1'b1;
            default: begin
                if (neg_i) begin
                    if (over || mag_i > lim_neg) begin
                        data_o = OUT_W'(0) - lim_neg[OUT_W-1:0];
                        inv_o  = 1'b1;
                    end else begin
                        data_o = OUT_W'(0) - mag_i[OUT_W-1:0];
                        inx_o  = lost_i;
                    end
                end else begin
                    if (over || mag_i > lim_pos) begin
                        data_o = lim_pos[OUT_W-1:0];
                        inv_o  = 1'b1;
                    end else begin
                        data_o = mag_i[OUT_W-1:0];
                        inx_o  = lost_i;
                    end
                end
            end
        endcase
    end

    // R6 / R7: a clamped result never also reports inexact.
    always_comb begin
        a_r7_clamp_no_inexact: assert (!(inv_o && inx_o))
            else $error("clamp raised both flags");
    end
endmodule

// File: rtl/f2x_convert.sv
module f2x_convert
    import f2x_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      in_bits,
    input  logic             in_signed,
    input  logic             in_half,
    input  logic [5:0]       in_fbits,
    input  logic             in_force_rz,
    input  logic [1:0]       in_rmode,
    output logic             out_valid,
    output logic [31:0]      out_data,
    output logic             out_invalid,
    output logic             out_inexact
);
    kind_e                  kind;
    logic                   neg;
    logic [SIG_W-1:0]       sig;
    logic signed [SH_W-1:0] shift;
    rmode_e                 mode;
    logic [MAG_W-1:0]       mag;
    logic                   big, lost;
    logic [OUT_W-1:0]       cl_data;
    logic                   cl_inv, cl_inx;
    stage_t                 st_d, st_q;

    assign mode = in_force_rz ? RM_ZERO : rmode_e'(in_rmode);

    f2x_unpack u_unpack (
        .bits_i (in_bits),
        .fbits_i(in_fbits),
        .kind_o (kind),
        .neg_o  (neg),
        .sig_o  (sig),
        .shift_o(shift)
    );

    f2x_round u_round (
        .sig_i  (sig),
        .shift_i(shift),
        .neg_i  (neg),
        .mode_i (mode),
        .mag_o  (mag),
        .big_o  (big),
        .lost_o (lost)
    );

    f2x_clamp u_clamp (
        .kind_i  (kind),
        .neg_i   (neg),
        .mag_i   (mag),
        .big_i   (big),
        .lost_i  (lost),
        .signed_i(in_signed),
        .half_i  (in_half),
        .data_o  (cl_data),
        .inv_o   (cl_inv),
        .inx_o   (cl_inx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.inv = 1'b0;
        st_d.inx = 1'b0;
        if (in_valid) begin
            st_d.data = cl_data;
            st_d.inv  = cl_inv;
            st_d.inx  = cl_inx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.vld;
    assign out_data    = st_q.data;
    assign out_invalid = st_q.inv;
    assign out_inexact = st_q.inx;

    a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r12_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r12_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_invalid && !out_inexact));
    a_r12_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    a_r6_no_double_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> !out_inexact);
    a_r4_nan_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bits[30:23] == 8'hFF && in_bits[22:0] != '0)
        |=> (out_invalid && out_data == '0));
    a_r11_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_half && in_signed)
        |=> (out_data[31:16] == {16{out_data[15]}}));
    a_r11_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_half && !in_signed) |=> (out_data[31:16] == '0));
endmodule

// File: tb/tb_f2x_convert.sv
`timescale 1ns/1ps
module tb_f2x_convert;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_bits = '0;
    logic        in_signed = 1'b0;
    logic        in_half = 1'b0;
    logic [5:0]  in_fbits = '0;
    logic        in_force_rz = 1'b0;
    logic [1:0]  in_rmode = '0;
    logic        out_valid, out_invalid, out_inexact;
    logic [31:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    f2x_convert dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
        .in_signed(in_signed), .in_half(in_half), .in_fbits(in_fbits),
        .in_force_rz(in_force_rz), .in_rmode(in_rmode),
        .out_valid(out_valid), .out_data(out_data),
        .out_invalid(out_invalid), .out_inexact(out_inexact)
    );

    // Independent model on real arithmetic.
    task automatic ref_conv(input logic [31:0] f, input logic sg, input logic hf,
                            input int fb_in, input logic frz, input logic [1:0] rm,
                            output logic [31:0] d, output logic inv, output logic inx);
        real lo, hi, v, fl, fp, r;
        int  e, fb, md;
        fb = (fb_in > 32) ? 32 : fb_in;
        e  = int'(f[30:23]);
        lo = sg ? (hf ? -32768.0 : -2147483648.0) : 0.0;
        hi = sg ? (hf ? 32767.0 : 2147483647.0) : (hf ? 65535.0 : 4294967295.0);
        d = '0; inv = 1'b0; inx = 1'b0;
        if (e == 255 && f[22:0] != 0) begin
            inv = 1'b1;
        end else if (e == 255) begin
            inv = 1'b1;
            d = f[31] ? 32'(longint'(lo)) : 32'(longint'(hi));
        end else if (e == 0 && f[22:0] != 0) begin
            inx = 1'b1;
        end else if (e != 0) begin
            v = real'({1'b1, f[22:0]}) * (2.0 ** (e - 150 + fb));
            if (f[31]) v = -v;
            fl = $floor(v);
            fp = v - fl;
            md = frz ? 3 : int'(rm);
            if (fp == 0.0) r = v;
            else case (md)
                0: if (fp > 0.5) r = fl + 1.0;
                   else if (fp < 0.5) r = fl;
                   else r = ((longint'(fl) % 2) == 0) ? fl : fl + 1.0;
                1: r = fl + 1.0;
                2: r = fl;
                default: r = (v < 0.0) ? fl + 1.0 : fl;
            endcase
            if (r < lo) begin
                d = 32'(longint'(lo)); inv = 1'b1;
            end else if (r > hi) begin
                d = 32'(longint'(hi)); inv = 1'b1;
            end else begin
                d = 32'(longint'(r)); inx = (fp != 0.0);
            end
        end
    endtask

    task automatic check3(input string tag, input string what,
                          input logic [31:0] ed, input logic ei, input logic ex);
        n_tests++;
        if (out_valid !== 1'b1 || out_data !== ed || out_invalid !== ei || out_inexact !== ex) begin
            n_fail++;
            $display("FAIL %s %s: got v=%b data=%h inv=%b inx=%b expected data=%h inv=%b inx=%b",
                     tag, what, out_valid, out_data, out_invalid, out_inexact, ed, ei, ex);
        end
    endtask

    task automatic drive(input logic [31:0] f, input logic sg, input logic hf,
                         input int fb, input logic frz, input logic [1:0] rm);
        @(negedge clk);
        in_bits = f; in_signed = sg; in_half = hf; in_fbits = 6'(fb);
        in_force_rz = frz; in_rmode = rm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Compare against the model.
    task automatic run_ref(input string tag, input logic [31:0] f, input logic sg,
                           input logic hf, input int fb, input logic frz, input logic [1:0] rm);
        logic [31:0] ed; logic ei, ex;
        ref_conv(f, sg, hf, fb, frz, rm, ed, ei, ex);
        drive(f, sg, hf, fb, frz, rm);
        check3(tag, $sformatf("model f=%h fb=%0d rm=%0d", f, fb, rm), ed, ei, ex);
    endtask

    // Compare against a hand-worked constant.
    task automatic run_exp(input string tag, input logic [31:0] f, input logic sg,
                           input logic hf, input int fb, input logic frz, input logic [1:0] rm,
                           input logic [31:0] ed, input logic ei, input logic ex);
        drive(f, sg, hf, fb, frz, rm);
        check3(tag, $sformatf("const f=%h fb=%0d rm=%0d", f, fb, rm), ed, ei, ex);
    endtask

    task automatic test_reset();
        n_tests++;
        if (out_valid !== 1'b0 || out_data !== '0 || out_invalid !== 1'b0 || out_inexact !== 1'b0) begin
            n_fail++;
            $display("FAIL R12 reset: got v=%b data=%h inv=%b inx=%b expected 0 0 0 0",
                     out_valid, out_data, out_invalid, out_inexact);
        end
    endtask

    task automatic test_scaling();
        run_exp("R1", 32'h3F800000, 1'b1, 1'b0, 0,  1'b0, 2'd0, 32'h1, 0, 0);
        run_exp("R1", 32'h3F800000, 1'b1, 1'b0, 16, 1'b0, 2'd0, 32'h10000, 0, 0);
        run_exp("R1", 32'h3F800000, 1'b0, 1'b0, 31, 1'b0, 2'd0, 32'h80000000, 0, 0);
        run_exp("R1", 32'h3F800000, 1'b1, 1'b0, 63, 1'b0, 2'd0, 32'h7FFFFFFF, 1, 0);
        run_ref("R1", 32'h3DCCCCCD, 1'b1, 1'b0, 16, 1'b0, 2'd0);
        run_ref("R1", 32'hC2F6E979, 1'b1, 1'b0, 8,  1'b0, 2'd0);
    endtask

    task automatic test_halfway_sweep();
        int fbs[6] = '{0, 1, 15, 16, 31, 32};
        foreach (fbs[i]) begin
            for (int m = 0; m < 4; m++) begin
                // +2.5, +3.5, -2.5 scaled down by 2^fb
                run_ref("R2", {1'b0, 8'(128 - fbs[i]), 23'h200000}, 1'b1, 1'b0, fbs[i], 1'b0, 2'(m));
                run_ref("R2", {1'b0, 8'(128 - fbs[i]), 23'h600000}, 1'b1, 1'b0, fbs[i], 1'b0, 2'(m));
                run_ref("R2", {1'b1, 8'(128 - fbs[i]), 23'h200000}, 1'b1, 1'b0, fbs[i], 1'b0, 2'(m));
            end
        end
    endtask

    task automatic test_rounding_consts();
        run_exp("R2", 32'h40200000, 1'b1, 1'b0, 0, 1'b0, 2'd0, 32'd2, 0, 1);
        run_exp("R2", 32'h40600000, 1'b1, 1'b0, 0, 1'b0, 2'd0, 32'd4, 0, 1);
        run_exp("R2", 32'h40200000, 1'b1, 1'b0, 0, 1'b0, 2'd1, 32'd3, 0, 1);
        run_exp("R2", 32'hC0200000, 1'b1, 1'b0, 0, 1'b0, 2'd2, 32'hFFFFFFFD, 0, 1);
        run_exp("R2", 32'hC0200000, 1'b1, 1'b0, 0, 1'b0, 2'd3, 32'hFFFFFFFE, 0, 1);
        run_exp("R5", 32'h40400000, 1'b1, 1'b0, 0, 1'b0, 2'd1, 32'd3, 0, 0);
    endtask

    task automatic test_force_rz();
        run_exp("R3", 32'h40300000, 1'b1, 1'b0, 0, 1'b1, 2'd1, 32'd2, 0, 1);
        run_exp("R3", 32'h40300000, 1'b1, 1'b0, 0, 1'b0, 2'd1, 32'd3, 0, 1);
        run_exp("R3", 32'hC0300000, 1'b1, 1'b0, 0, 1'b1, 2'd2, 32'hFFFFFFFE, 0, 1);
    endtask

    task automatic test_specials();
        run_exp("R4",  32'h7FC00000, 1'b1, 1'b0, 0,  1'b0, 2'd0, 32'h0, 1, 0);
        run_exp("R4",  32'hFF800001, 1'b0, 1'b1, 5,  1'b0, 2'd1, 32'h0, 1, 0);
        run_exp("R9",  32'h7F800000, 1'b1, 1'b0, 0,  1'b0, 2'd0, 32'h7FFFFFFF, 1, 0);
        run_exp("R9",  32'hFF800000, 1'b1, 1'b1, 0,  1'b0, 2'd0, 32'hFFFF8000, 1, 0);
        run_exp("R9",  32'hFF800000, 1'b0, 1'b1, 0,  1'b0, 2'd0, 32'h0, 1, 0);
        run_exp("R10", 32'h00000001, 1'b1, 1'b0, 32, 1'b0, 2'd1, 32'h0, 0, 1);
        run_exp("R10", 32'h80000000, 1'b1, 1'b0, 32, 1'b0, 2'd2, 32'h0, 0, 0);
    endtask

    task automatic test_saturation();
        run_exp("R7", 32'h471C4000, 1'b1, 1'b1, 0, 1'b0, 2'd0, 32'h00007FFF, 1, 0);
        run_exp("R7", 32'h471C4000, 1'b0, 1'b1, 0, 1'b0, 2'd0, 32'h00009C40, 0, 0);
        run_exp("R6", 32'hC71C4000, 1'b1, 1'b1, 0, 1'b0, 2'd0, 32'hFFFF8000, 1, 0);
        run_exp("R7", 32'h4F000000, 1'b1, 1'b0, 0, 1'b0, 2'd0, 32'h7FFFFFFF, 1, 0);
        run_exp("R6", 32'hCF000000, 1'b1, 1'b0, 0, 1'b0, 2'd0, 32'h80000000, 0, 0);
        run_exp("R7", 32'h4F800000, 1'b0, 1'b0, 0, 1'b0, 2'd0, 32'hFFFFFFFF, 1, 0);
        // 32767.75 rounds to 32768: clamped, inexact dropped
        run_exp("R7", 32'h46FFFF80, 1'b1, 1'b1, 0, 1'b0, 2'd0, 32'h00007FFF, 1, 0);
        run_exp("R5", 32'h46FFFF80, 1'b1, 1'b1, 0, 1'b0, 2'd2, 32'h00007FFF, 0, 1);
        run_exp("R6", 32'hC7000080, 1'b1, 1'b1, 0, 1'b0, 2'd2, 32'hFFFF8000, 1, 0);
    endtask

    task automatic test_unsigned_negative();
        run_exp("R8", 32'hBF800000, 1'b0, 1'b0, 0, 1'b0, 2'd0, 32'h0, 1, 0);
        run_exp("R8", 32'hBE99999A, 1'b0, 1'b0, 0, 1'b0, 2'd0, 32'h0, 0, 1);
        run_exp("R8", 32'hBF333333, 1'b0, 1'b0, 0, 1'b0, 2'd0, 32'h0, 1, 0);
        run_exp("R8", 32'hBF333333, 1'b0, 1'b1, 0, 1'b0, 2'd3, 32'h0, 0, 1);
    endtask

    task automatic test_extension();
        run_exp("R11", 32'hC0A00000, 1'b1, 1'b1, 0, 1'b0, 2'd0, 32'hFFFFFFFB, 0, 0);
        run_exp("R11", 32'h47435000, 1'b0, 1'b1, 0, 1'b0, 2'd0, 32'h0000C350, 0, 0);
        run_ref("R11", 32'hC2F6E979, 1'b1, 1'b1, 4, 1'b0, 2'd1);
    endtask

    task automatic test_hold();
        logic [31:0] prev;
        drive(32'h40A00000, 1'b1, 1'b0, 0, 1'b0, 2'd0);
        prev = out_data;
        @(negedge clk);
        in_bits = 32'h7FC00000;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            n_tests++;
            if (out_valid !== 1'b0 || out_data !== prev || out_invalid !== 1'b0 || out_inexact !== 1'b0) begin
                n_fail++;
                $display("FAIL R12 idle: got v=%b data=%h inv=%b inx=%b expected 0 %h 0 0",
                         out_valid, out_data, out_invalid, out_inexact, prev);
            end
        end
    endtask

    task automatic test_mixed();
        logic [31:0] pats[8] = '{32'h3F7FFFFF, 32'h4B000001, 32'hBDCCCCCD, 32'h3F000000,
                                 32'hBF000000, 32'h3FC00000, 32'h477FFF80, 32'h2F800000};
        foreach (pats[i])
            for (int m = 0; m < 4; m++) begin
                run_ref("R5", pats[i], 1'b1, 1'b0, 1, 1'b0, 2'(m));
                run_ref("R5", pats[i], 1'b0, 1'b1, 0, 1'b0, 2'(m));
                run_ref("R1", pats[i], 1'b1, 1'b0, 32, 1'b0, 2'(m));
            end
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_scaling();
        test_halfway_sweep();
        test_rounding_consts();
        test_force_rz();
        test_specials();
        test_saturation();
        test_unsigned_negative();
        test_extension();
        test_hold();
        test_mixed();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule